// File: doc/BRIEF.md
# Prioritized Pending Interrupt Arbiter

This block collects interrupt requests from fourteen named sources into a vector of pending bits. When the core allows a delivery, the block picks one source and reports it. The choice follows a fixed priority ladder, and each rung of the ladder may be gated by processor state. Each source raises its request with a one-cycle set pulse. The core opens an arbitration slot by holding `arb_en_i` high for a cycle. The block answers with a one-cycle `take_o` strobe and an encoded source identifier on `exc_id_o`. In the same edge it retires the pending bit of the winner.

The two external sources can be declared level-signalled through `ext_level_i`. In that mode, taking them leaves their pending bit set, because the outside line is still asserted. Every other source is retired when it is taken. The core clears its own state elsewhere: the block does not save return addresses, compute vectors or change processor modes.

Top module: `irq_arbiter`

## Requirements
- R1: After reset no source is pending, `take_o` is 0 and `exc_id_o` reads the idle code 15.
- R2: A set pulse on `set_i[k]` in one cycle makes source k pending from the next edge on. An arbitration slot after that edge delivers it: `take_o`=1 and `exc_id_o`=k in the cycle after the slot.
- R3: Source bit positions and identifier codes are equal, and the lower code wins: 0 reset, 1 machine check, 2 external debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable interval timer, 9 decrementer, 10 external, 11 doorbell, 12 performance monitor, 13 thermal.
- R4: Each slot delivers at most one source. `take_o` is a single-cycle strobe and stays 0 after any cycle in which `arb_en_i` is 0.
- R5: Reset (0) and external debug (2) are delivered regardless of any enable input.
- R6: Machine check (1) is delivered only while `me_i`=1.
- R7: The hypervisor decrementer (3) is delivered only while `hdec_en_i`=1 and at least one of these holds: `ee_i`=1, `hv_i`=0, or `pr_i`=1.
- R8: Sources 4 to 6 are delivered only while `ce_i`=1.
- R9: Sources 7 to 13 are delivered only while `ee_i`=1.
- R10: A pending source that is gated off keeps its bit. It does not block lower-priority eligible sources, and it is delivered once its gate opens.
- R11: With `ext_level_i`=1, delivering source 4 or 10 leaves its bit pending. With `ext_level_i`=0, delivering them clears the bit.
- R12: Every source other than 4 and 10 has its pending bit cleared in the edge that delivers it.
- R13: If a set pulse and the delivery clear hit the same bit in one edge, the bit stays pending.
- R14: A slot with no eligible pending source gives `take_o`=0 and `exc_id_o`=15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| set_i | input | 14 | One-cycle set pulse per source, bit index = source code |
| ext_level_i | input | 1 | 1: sources 4 and 10 are level-signalled |
| arb_en_i | input | 1 | Arbitration slot open this cycle |
| me_i | input | 1 | Machine-check enable |
| ee_i | input | 1 | External enable, gates sources 7 to 13 |
| ce_i | input | 1 | Critical enable, gates sources 4 to 6 |
| hv_i | input | 1 | Core is in hypervisor state |
| pr_i | input | 1 | Core is in problem state |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| take_o | output | 1 | One-cycle delivery strobe |
| exc_id_o | output | 4 | Delivered source code, 15 when idle |

## Verification
A set pulse takes one edge to become pending. A slot opened in the following cycle registers its result on `take_o` and `exc_id_o` at the slot's own edge. So the result of a slot is valid in the cycle right after the slot and is gone one cycle later. The bench drives every input at the falling edge and holds `arb_en_i` for exactly one cycle. It reads the outputs at the next falling edge, which lies between the slot's edge and the one after it. It reads them again one cycle later to check that the strobe has ended. The bench never looks at the pending state directly. Retained, retired and gated bits are all observed through later slots.

// File: rtl/irq_arb_pkg.sv
// Shared definitions for the pending interrupt arbiter.
// Assumes: source bit index equals its delivery code, lower code wins.
package irq_arb_pkg;

    localparam int NUM_SRC = 14;
    localparam int ID_W    = $clog2(NUM_SRC + 2);

    typedef enum logic [ID_W-1:0] {
        SRC_RESET  = 4'd0,
        SRC_MCHK   = 4'd1,
        SRC_DEBUG  = 4'd2,
        SRC_HDEC   = 4'd3,
        SRC_CEXT   = 4'd4,
        SRC_WDOG   = 4'd5,
        SRC_CDBELL = 4'd6,
        SRC_FIT    = 4'd7,
        SRC_PIT    = 4'd8,
        SRC_DEC    = 4'd9,
        SRC_EXT    = 4'd10,
        SRC_DBELL  = 4'd11,
        SRC_PERF   = 4'd12,
        SRC_THERM  = 4'd13,
        SRC_NONE   = 4'd15
    } src_id_e;

    // Which processor-state condition opens a source
    typedef enum logic [2:0] {
        G_ALWAYS,
        G_MCHK,
        G_HDEC,
        G_CRIT,
        G_NONCRIT
    } gate_e;

    // Gate class of a source, by its priority rank
    function automatic gate_e gate_of(int idx);
        if (idx == int'(SRC_RESET) || idx == int'(SRC_DEBUG)) return G_ALWAYS;
        if (idx == int'(SRC_MCHK))                            return G_MCHK;
        if (idx == int'(SRC_HDEC))                            return G_HDEC;
        if (idx >= int'(SRC_CEXT) && idx <= int'(SRC_CDBELL)) return G_CRIT;
        return G_NONCRIT;
    endfunction

    // Sources whose pending bit survives delivery in level mode
    function automatic logic [NUM_SRC-1:0] level_mask();
        logic [NUM_SRC-1:0] m;
        m = '0;
        m[SRC_CEXT] = 1'b1;
        m[SRC_EXT]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_pend_store.sv
// Pending request store: one bit per source.
// Set pulses and delivery clears land in the same edge; a set wins.
// Assumes clr_i carries at most one bit.
module irq_pend_store #(
    parameter int NSRC = irq_arb_pkg::NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);

    logic [NSRC-1:0] pend_q;

    // Retire cleared bits, then merge new requests on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
        end
    end

    assign pend_o = pend_q;

    // R13: a set pulse is never lost, even against a clear
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R12: a clear with no competing set empties the bit
    a_r12_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

    // R4: delivery retires at most one source per edge
    a_r4_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_i));

endmodule

// File: rtl/irq_gate.sv
// Eligibility gating: masks each pending bit with the processor-state
// condition of its class. Purely combinational.
module irq_gate #(
    parameter int NSRC = irq_arb_pkg::NUM_SRC
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic            me_i,
    input  logic            ee_i,
    input  logic            ce_i,
    input  logic            hv_i,
    input  logic            pr_i,
    input  logic            hdec_en_i,
    output logic [NSRC-1:0] elig_o
);
    import irq_arb_pkg::*;

    logic hdec_open;

    // Hypervisor decrementer: own enable plus any one of three states
    assign hdec_open = hdec_en_i && (ee_i || !hv_i || pr_i);

    // One gate per source, chosen by its class
    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        localparam gate_e CLS = gate_of(i);
        if (CLS == G_ALWAYS) begin : g_always
            assign elig_o[i] = pend_i[i];
        end else if (CLS == G_MCHK) begin : g_mchk
            assign elig_o[i] = pend_i[i] && me_i;
        end else if (CLS == G_HDEC) begin : g_hdec
            assign elig_o[i] = pend_i[i] && hdec_open;
        end else if (CLS == G_CRIT) begin : g_crit
            assign elig_o[i] = pend_i[i] && ce_i;
        end else begin : g_noncrit
            assign elig_o[i] = pend_i[i] && ee_i;
        end
    end

endmodule

// File: rtl/irq_pick.sv
// Fixed-priority picker: the lowest-indexed eligible source wins.
// Gives the winner as a code and as a one-hot vector.
module irq_pick #(
    parameter int NSRC = irq_arb_pkg::NUM_SRC,
    parameter int IDW  = irq_arb_pkg::ID_W
) (
    input  logic [NSRC-1:0] elig_i,
    output logic [NSRC-1:0] win_oh_o,
    output logic [IDW-1:0]  win_id_o,
    output logic            any_o
);
    import irq_arb_pkg::*;

    // Scan from lowest priority up so the highest one is written last
    always_comb begin
        win_oh_o = '0;
        win_id_o = SRC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                win_oh_o    = '0;
                win_oh_o[i] = 1'b1;
                win_id_o    = IDW'(i);
            end
        end
    end

    assign any_o = |elig_i;

endmodule

// File: rtl/irq_arbiter.sv
// Prioritized pending interrupt arbiter (top).
// Stores requests, gates them by processor state, and delivers the
// highest-priority eligible one per open slot. Outputs are registered:
// a slot at edge k shows on take_o/exc_id_o right after edge k.
// Assumes arb_en_i is driven by the core once delivery is allowed.
module irq_arbiter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [13:0] set_i,
    input  logic        ext_level_i,
    input  logic        arb_en_i,
    input  logic        me_i,
    input  logic        ee_i,
    input  logic        ce_i,
    input  logic        hv_i,
    input  logic        pr_i,
    input  logic        hdec_en_i,
    output logic        take_o,
    output logic [3:0]  exc_id_o
);
    import irq_arb_pkg::*;

    localparam int              NSRC     = NUM_SRC;
    localparam logic [NSRC-1:0] LVL_MASK = level_mask();

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] win_oh;
    logic [NSRC-1:0] clr_vec;
    logic [ID_W-1:0] win_id;
    logic            any_elig;
    logic            grant;
    logic            take_q;
    logic [ID_W-1:0] id_q;

    irq_pend_store #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_i),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    irq_gate #(.NSRC(NSRC)) u_gate (
        .pend_i    (pend),
        .me_i      (me_i),
        .ee_i      (ee_i),
        .ce_i      (ce_i),
        .hv_i      (hv_i),
        .pr_i      (pr_i),
        .hdec_en_i (hdec_en_i),
        .elig_o    (elig)
    );

    irq_pick #(.NSRC(NSRC), .IDW(ID_W)) u_pick (
        .elig_i   (elig),
        .win_oh_o (win_oh),
        .win_id_o (win_id),
        .any_o    (any_elig)
    );

    // A slot grants only when something is eligible
    assign grant = arb_en_i && any_elig;

    // Retire the winner unless it is a level-signalled external source
    assign clr_vec = grant ? (win_oh & ~(ext_level_i ? LVL_MASK : '0)) : '0;

    // Register the delivery strobe and the code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            id_q   <= SRC_NONE;
        end else begin
            take_q <= grant;
            id_q   <= grant ? win_id : SRC_NONE;
        end
    end

    assign take_o   = take_q;
    assign exc_id_o = id_q;

    // R4: no strobe without a slot
    a_r4_strobe_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en_i |=> !take_o);

    // R14: a strobe always carries a real source code
    a_r14_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (exc_id_o != SRC_NONE && exc_id_o < 4'(NSRC)));

    // R5: pending reset wins any slot
    a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && pend[SRC_RESET]) |=> (take_o && exc_id_o == SRC_RESET));

    // R6: no machine check while its enable is low
    a_r6_mchk_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && !me_i) |=> (exc_id_o != SRC_MCHK));

    // R8: critical tier closed while critical enable is low
    a_r8_crit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && !ce_i) |=> !(exc_id_o >= SRC_CEXT && exc_id_o <= SRC_CDBELL));

    // R9: non-critical tier closed while external enable is low
    a_r9_noncrit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && !ee_i) |=> !(exc_id_o >= SRC_FIT && exc_id_o <= SRC_THERM));

    // R11: a level-mode external delivery leaves its bit pending
    a_r11_level_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && ext_level_i && pend[SRC_EXT]) |=> pend[SRC_EXT]);

endmodule

// File: tb/sim_irq_arbiter.sv
// Directed bench for irq_arbiter: one task per scenario.
module sim_irq_arbiter;
    import irq_arb_pkg::*;

    localparam int NONE = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] set_i = '0;
    logic        ext_level = 1'b0;
    logic        arb_en = 1'b0;
    logic        me = 1'b1, ee = 1'b1, ce = 1'b1, hv = 1'b0, pr = 1'b0, hden = 1'b1;
    logic        take;
    logic [3:0]  id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .ext_level_i(ext_level),
        .arb_en_i(arb_en), .me_i(me), .ee_i(ee), .ce_i(ce), .hv_i(hv),
        .pr_i(pr), .hdec_en_i(hden), .take_o(take), .exc_id_o(id)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic post(logic [13:0] m);
        @(negedge clk) set_i = m;
        @(negedge clk) set_i = '0;
    endtask

    // One slot; optional set pulse in the same cycle; result read next falling edge
    task automatic slot(string tag, int exp_id, logic [13:0] m = '0);
        @(negedge clk);
        set_i  = m;
        arb_en = 1'b1;
        @(negedge clk);
        set_i  = '0;
        arb_en = 1'b0;
        chk({tag, " take"}, int'(take), (exp_id == NONE) ? 0 : 1);
        chk({tag, " id"}, int'(id), exp_id);
    endtask

    task automatic gates(logic m_me, logic m_ce, logic m_ee, logic m_hv,
                         logic m_pr, logic m_hden);
        @(negedge clk);
        me = m_me; ce = m_ce; ee = m_ee; hv = m_hv; pr = m_pr; hden = m_hden;
    endtask

    // Empty the store between scenarios (not counted as checks)
    task automatic drain();
        gates(1, 1, 1, 0, 0, 1);
        ext_level = 1'b0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk) arb_en = 1'b1;
            @(negedge clk) arb_en = 1'b0;
            if (!take) break;
        end
    endtask

    task automatic t_reset();
        chk("R1 take after reset", int'(take), 0);
        chk("R1 id after reset", int'(id), NONE);
        slot("R14 empty slot", NONE);
    endtask

    task automatic t_single();
        post(14'(1) << SRC_DEC);
        slot("R2 single dec", int'(SRC_DEC));
        @(negedge clk);
        chk("R4 strobe ends", int'(take), 0);
        slot("R12 dec retired", NONE);
    endtask

    task automatic t_priority();
        post('1);
        for (int k = 0; k < 14; k++) slot($sformatf("R3 rank %0d", k), k);
        slot("R12 all retired", NONE);
    endtask

    task automatic t_always();
        gates(0, 0, 0, 1, 0, 0);
        post('1);
        slot("R5 reset ungated", int'(SRC_RESET));
        slot("R5 debug ungated", int'(SRC_DEBUG));
        slot("R14 all gated", NONE);
        gates(1, 1, 1, 0, 0, 1);
        slot("R10 mchk kept", int'(SRC_MCHK));
        slot("R10 hdec kept", int'(SRC_HDEC));
        drain();
    endtask

    task automatic t_mchk();
        gates(0, 1, 1, 0, 0, 1);
        post((14'(1) << SRC_MCHK) | (14'(1) << SRC_DEC));
        slot("R10 skip gated mchk", int'(SRC_DEC));
        slot("R6 mchk blocked", NONE);
        gates(1, 1, 1, 0, 0, 1);
        slot("R6 mchk enabled", int'(SRC_MCHK));
    endtask

    task automatic t_hdec();
        post(14'(1) << SRC_HDEC);
        gates(1, 1, 1, 0, 0, 0);
        slot("R7 hdec enable off", NONE);
        gates(1, 1, 0, 1, 0, 1);
        slot("R7 hv no ee no pr", NONE);
        gates(1, 1, 0, 0, 0, 1);
        slot("R7 not hv", int'(SRC_HDEC));
        post(14'(1) << SRC_HDEC);
        gates(1, 1, 0, 1, 1, 1);
        slot("R7 problem state", int'(SRC_HDEC));
        post(14'(1) << SRC_HDEC);
        gates(1, 1, 1, 1, 0, 1);
        slot("R7 ee set", int'(SRC_HDEC));
    endtask

    task automatic t_tiers();
        gates(1, 0, 1, 0, 0, 1);
        post((14'(1) << SRC_WDOG) | (14'(1) << SRC_FIT));
        slot("R8 wdog gated fit goes", int'(SRC_FIT));
        slot("R8 wdog still gated", NONE);
        gates(1, 1, 1, 0, 0, 1);
        slot("R8 wdog enabled", int'(SRC_WDOG));
        gates(1, 1, 0, 0, 0, 1);
        post(14'(1) << SRC_THERM);
        slot("R9 therm gated", NONE);
        gates(1, 1, 1, 0, 0, 1);
        slot("R9 therm enabled", int'(SRC_THERM));
    endtask

    task automatic t_level();
        @(negedge clk) ext_level = 1'b1;
        post(14'(1) << SRC_EXT);
        slot("R11 level ext", int'(SRC_EXT));
        slot("R11 level ext kept", int'(SRC_EXT));
        post(14'(1) << SRC_CEXT);
        slot("R11 level cext", int'(SRC_CEXT));
        slot("R11 level cext kept", int'(SRC_CEXT));
        @(negedge clk) ext_level = 1'b0;
        slot("R11 edge cext", int'(SRC_CEXT));
        slot("R11 edge ext", int'(SRC_EXT));
        slot("R11 edge cleared", NONE);
    endtask

    task automatic t_setwins();
        post(14'(1) << SRC_DEC);
        slot("R13 take with set", int'(SRC_DEC), 14'(1) << SRC_DEC);
        slot("R13 bit survived", int'(SRC_DEC));
        slot("R13 then retired", NONE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_always();
        t_mchk();
        drain();
        t_hdec();
        drain();
        t_tiers();
        drain();
        t_level();
        drain();
        t_setwins();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule